// File: doc/BRIEF.md
# Programmable RAM-Based Complex FIR Decimator

This block filters a stream of complex samples with a single multiply-accumulate datapath. The datapath walks the filter taps one per clock. Each input sample is 18 bits for I and 18 bits for Q, and arrives with a valid strobe. Every accepted sample is stored in a circular history memory. Every (dec_m1+1)-th accepted sample starts a new computation, which walks taps from the newest stored sample to the oldest. Each tap multiplies a 20-bit coefficient by a stored sample and adds the product to the I and Q accumulators. The block accepts no new sample while a computation is running.

A control port reads and writes both memories. Address bit 8 selects between them: 0 for coefficients, 1 for history. Four settings are sampled when a computation starts:

- the tap count minus one;
- a coefficient base offset, so that several filters can stay resident in coefficient memory;
- a dual-channel flag, under which I and Q are two independent real channels with their own coefficient halves;
- the decimation rate minus one.

The block presents two results. The first is a saturated 23-bit sum. The second is a 16-bit view of that sum, chosen by a live 3-bit shift code and rounded.

Top module: `rfir_dec`

## Requirements
- R1: The coefficient memory holds 256 signed 20-bit words. It is written when cfg_we is high and cfg_addr[8]=0. One cycle after cfg_addr is presented with bit 8 at 0, cfg_rdata returns the word at cfg_addr[7:0] in bits 19:0, with bits 35:20 zero.
- R2: The history memory holds 256 words of 36 bits, with I in bits 17:0 and Q in bits 35:18. It is written and read like the coefficient memory, but with cfg_addr[8]=1. Reset does not clear its contents.
- R3: Each accepted input (in_valid and in_ready high at a clock edge) is stored as {in_q, in_i} at a write pointer. The pointer then advances by one modulo 256. Reset sets the pointer to 0.
- R4: Complex mode (dual_mode=0) uses N = taps_m1+1 taps. Each output is the sum over k = 0..N-1 of coef[(coef_base+k) mod 256] times the I or Q part of hist[(newest-k) mod 256], where newest is the slot of the sample that started the computation.
- R5: Dual mode (dual_mode=1) uses N = min(taps_m1,127)+1 taps. I uses coef[(coef_base+k) mod 256]. Q uses coef[(coef_base+128+k) mod 256].
- R6: A computation starts on every (dec_m1+1)-th accepted input. Reset clears the phase count. Inputs that do not start a computation leave in_ready high and produce no out_valid.
- R7: in_ready falls after the accept that starts a computation and stays low until out_valid. Inputs presented during this time are ignored and not stored.
- R8: out_valid is a one-cycle pulse that appears N+1 clock edges after the starting accept in complex mode, and 2N+1 edges after it in dual mode. res_i and res_q change only at that pulse and are held until the next one.
- R9: res_i and res_q equal the full sum shifted right arithmetically by 19, then saturated to the range -2^22 to 2^22-1.
- R10: out16_i and out16_q follow the current out_shift S. Each is the result shifted right arithmetically by 7-S after adding 2^(6-S) when S<7, then saturated to the range -32768 to 32767.
- R11: Coefficient and history addresses wrap modulo 256, so a filter whose base offset plus taps passes 255 continues at address 0.
- R12: During and after reset, in_ready=1, out_valid=0, and res_i, res_q, out16_i, out16_q and cfg_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 18 | Input I sample, signed |
| in_q | input | 18 | Input Q sample, signed |
| in_ready | output | 1 | High when an input can be accepted |
| taps_m1 | input | 8 | Tap count minus one |
| coef_base | input | 8 | Coefficient memory base offset |
| dec_m1 | input | 8 | Decimation rate minus one |
| dual_mode | input | 1 | 1: two real channels, 0: one complex channel |
| out_shift | input | 3 | Shift code for the 16-bit view |
| cfg_we | input | 1 | Control port write enable |
| cfg_addr | input | 9 | Control address; bit 8 selects history memory |
| cfg_wdata | input | 36 | Control write data |
| cfg_rdata | output | 36 | Control read data, one cycle after the address |
| out_valid | output | 1 | Result pulse |
| res_i | output | 23 | Saturated I sum |
| res_q | output | 23 | Saturated Q sum |
| out16_i | output | 16 | Scaled and rounded I |
| out16_q | output | 16 | Scaled and rounded Q |

## Verification
The hardest condition to reach is saturation of the 23-bit sum. With realistic data it needs at least 32 taps of near full-scale products that all have the same sign. The bench fills the history memory through the control port with extreme I and Q values of opposite sign and fills a coefficient region with the largest positive value. One input then drives I to the top limit and Q to the bottom limit. The 128-tap clamp in dual mode is reached by setting a tap count of 201 and measuring the 257-edge latency. A held input strobe during a computation tests that busy-time inputs are not stored.

// File: rtl/rfir_pkg.sv
package rfir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } rfir_state_e;
endpackage

// File: rtl/rfir_ram.sv
// Register-array memory with one write port and two asynchronous read ports.
module rfir_ram #(
    parameter int AW = 8,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // No reset: contents survive a reset.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rfir_sat.sv
// Drops FRAC fraction bits from the accumulator and saturates to OUT_W.
module rfir_sat #(
    parameter int IN_W  = 46,
    parameter int FRAC  = 19,
    parameter int OUT_W = 23
) (
    input  logic signed [IN_W-1:0]  acc,
    output logic signed [OUT_W-1:0] res
);
    localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [IN_W-1:0] shifted;

    always_comb begin
        shifted = acc >>> FRAC;
        if (shifted > HI)      res = HI[OUT_W-1:0];
        else if (shifted < LO) res = LO[OUT_W-1:0];
        else                   res = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/rfir_outscale.sv
// Shift right by (2^SW-1 - code), round half up, saturate to OUT_W.
module rfir_outscale #(
    parameter int RES_W = 23,
    parameter int OUT_W = 16,
    parameter int SW    = 3
) (
    input  logic        [SW-1:0]    shift_code,
    input  logic signed [RES_W-1:0] res,
    output logic signed [OUT_W-1:0] out_word
);
    localparam int TOP = (1 << SW) - 1;
    localparam int EW  = RES_W + 1;
    localparam logic signed [EW-1:0] HI = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic        [SW-1:0] sh;
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] bias;
    logic signed [EW-1:0] summed;
    logic signed [EW-1:0] shifted;

    always_comb begin
        sh      = SW'(TOP) - shift_code;
        ext     = {res[RES_W-1], res};
        bias    = (sh == '0) ? '0 : (EW'(1) << (sh - 1'b1));
        summed  = ext + bias;
        shifted = summed >>> sh;
        if (shifted > HI)      out_word = HI[OUT_W-1:0];
        else if (shifted < LO) out_word = LO[OUT_W-1:0];
        else                   out_word = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/rfir_dec.sv
module rfir_dec
    import rfir_pkg::*;
#(
    parameter int SAMP_W  = 18,
    parameter int COEF_W  = 20,
    parameter int RES_W   = 23,
    parameter int OUT_W   = 16,
    parameter int SHIFT_W = 3,
    parameter int ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [SAMP_W-1:0]  in_i,
    input  logic signed [SAMP_W-1:0]  in_q,
    output logic                      in_ready,
    input  logic [ADDR_W-1:0]         taps_m1,
    input  logic [ADDR_W-1:0]         coef_base,
    input  logic [ADDR_W-1:0]         dec_m1,
    input  logic                      dual_mode,
    input  logic [SHIFT_W-1:0]        out_shift,
    input  logic                      cfg_we,
    input  logic [ADDR_W:0]           cfg_addr,
    input  logic [2*SAMP_W-1:0]       cfg_wdata,
    output logic [2*SAMP_W-1:0]       cfg_rdata,
    output logic                      out_valid,
    output logic signed [RES_W-1:0]   res_i,
    output logic signed [RES_W-1:0]   res_q,
    output logic signed [OUT_W-1:0]   out16_i,
    output logic signed [OUT_W-1:0]   out16_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = DEPTH / 2;
    localparam int HIST_W = 2 * SAMP_W;
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int ACC_W  = PROD_W + ADDR_W;
    localparam int FRAC   = COEF_W - 1;

    typedef struct packed {
        rfir_state_e             st;
        logic [ADDR_W-1:0]       wptr;
        logic [ADDR_W-1:0]       phase;
        logic [ADDR_W-1:0]       tap;
        logic [ADDR_W-1:0]       last;
        logic [ADDR_W-1:0]       base;
        logic [ADDR_W-1:0]       newest;
        logic                    pass;
        logic                    dual;
        logic                    ovalid;
        logic signed [ACC_W-1:0] acc_i;
        logic signed [ACC_W-1:0] acc_q;
        logic signed [RES_W-1:0] res_i;
        logic signed [RES_W-1:0] res_q;
        logic [HIST_W-1:0]       rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic                     accept;
    logic [ADDR_W-1:0]        coef_ra, hist_ra, hist_wa, lim_m1;
    logic [COEF_W-1:0]        coef_rd, coef_cfg_rd;
    logic [HIST_W-1:0]        hist_rd, hist_cfg_rd, hist_wd;
    logic                     hist_we, coef_we;
    logic signed [COEF_W-1:0] c_s;
    logic signed [SAMP_W-1:0] s_i, s_q;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0]  acc_lane [2];
    logic signed [RES_W-1:0]  sat_lane [2];
    logic signed [RES_W-1:0]  res_lane [2];
    logic signed [OUT_W-1:0]  o16_lane [2];

    assign in_ready = (r_q.st == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // Address generation: second pass of dual mode uses the upper half.
    assign coef_ra = r_q.base + r_q.tap + (r_q.pass ? ADDR_W'(HALF) : '0);
    assign hist_ra = r_q.newest - r_q.tap;
    assign lim_m1  = (dual_mode && (taps_m1 > ADDR_W'(HALF - 1))) ? ADDR_W'(HALF - 1) : taps_m1;

    // The sample stream has priority over the control port on the history write port.
    assign hist_we = accept || (cfg_we && cfg_addr[ADDR_W]);
    assign hist_wa = accept ? r_q.wptr : cfg_addr[ADDR_W-1:0];
    assign hist_wd = accept ? {in_q, in_i} : cfg_wdata;
    assign coef_we = cfg_we && !cfg_addr[ADDR_W];

    rfir_ram #(.AW(ADDR_W), .DW(COEF_W)) u_coef (
        .clk     (clk),
        .we      (coef_we),
        .waddr   (cfg_addr[ADDR_W-1:0]),
        .wdata   (cfg_wdata[COEF_W-1:0]),
        .raddr_a (coef_ra),
        .rdata_a (coef_rd),
        .raddr_b (cfg_addr[ADDR_W-1:0]),
        .rdata_b (coef_cfg_rd)
    );

    rfir_ram #(.AW(ADDR_W), .DW(HIST_W)) u_hist (
        .clk     (clk),
        .we      (hist_we),
        .waddr   (hist_wa),
        .wdata   (hist_wd),
        .raddr_a (hist_ra),
        .rdata_a (hist_rd),
        .raddr_b (cfg_addr[ADDR_W-1:0]),
        .rdata_b (hist_cfg_rd)
    );

    assign c_s    = coef_rd;
    assign s_i    = hist_rd[SAMP_W-1:0];
    assign s_q    = hist_rd[HIST_W-1:SAMP_W];
    assign prod_i = PROD_W'(c_s) * PROD_W'(s_i);
    assign prod_q = PROD_W'(c_s) * PROD_W'(s_q);

    assign acc_lane[0] = r_q.acc_i;
    assign acc_lane[1] = r_q.acc_q;
    assign res_lane[0] = r_q.res_i;
    assign res_lane[1] = r_q.res_q;

    for (genvar L = 0; L < 2; L++) begin : g_lane
        rfir_sat #(.IN_W(ACC_W), .FRAC(FRAC), .OUT_W(RES_W)) u_sat (
            .acc (acc_lane[L]),
            .res (sat_lane[L])
        );
        rfir_outscale #(.RES_W(RES_W), .OUT_W(OUT_W), .SW(SHIFT_W)) u_scale (
            .shift_code (out_shift),
            .res        (res_lane[L]),
            .out_word   (o16_lane[L])
        );
    end

    always_comb begin
        r_d        = r_q;
        r_d.ovalid = 1'b0;
        r_d.rdata  = cfg_addr[ADDR_W] ? hist_cfg_rd
                                      : {{(HIST_W-COEF_W){1'b0}}, coef_cfg_rd};
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.wptr = r_q.wptr + 1'b1;
                    if (r_q.phase >= dec_m1) begin
                        r_d.phase  = '0;
                        r_d.st     = ST_RUN;
                        r_d.tap    = '0;
                        r_d.pass   = 1'b0;
                        r_d.acc_i  = '0;
                        r_d.acc_q  = '0;
                        r_d.newest = r_q.wptr;
                        r_d.base   = coef_base;
                        r_d.dual   = dual_mode;
                        r_d.last   = lim_m1;
                    end else begin
                        r_d.phase = r_q.phase + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (!r_q.dual || !r_q.pass)
                    r_d.acc_i = r_q.acc_i + {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
                if (!r_q.dual || r_q.pass)
                    r_d.acc_q = r_q.acc_q + {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
                if (r_q.tap == r_q.last) begin
                    if (r_q.dual && !r_q.pass) begin
                        r_d.pass = 1'b1;
                        r_d.tap  = '0;
                    end else begin
                        r_d.st = ST_FIN;
                    end
                end else begin
                    r_d.tap = r_q.tap + 1'b1;
                end
            end
            ST_FIN: begin
                r_d.res_i  = sat_lane[0];
                r_d.res_q  = sat_lane[1];
                r_d.ovalid = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_rdata = r_q.rdata;
    assign out_valid = r_q.ovalid;
    assign res_i     = r_q.res_i;
    assign res_q     = r_q.res_q;
    assign out16_i   = o16_lane[0];
    assign out16_q   = o16_lane[1];
endmodule

// File: rtl/rfir_dec_chk.sv
module rfir_dec_chk #(
    parameter int RES_W = 23
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic signed [RES_W-1:0] res_i,
    input logic signed [RES_W-1:0] res_q
);
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_pulse_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(res_i) && $stable(res_q)));

    p_busy_from_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

    p_pulse_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!in_ready));
endmodule

bind rfir_dec rfir_dec_chk #(.RES_W(RES_W)) u_rfir_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .res_i     (res_i),
    .res_q     (res_q)
);

// File: tb/rfir_dec_test.sv
module rfir_dec_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               in_valid;
    logic signed [17:0] in_i, in_q;
    logic               in_ready;
    logic [7:0]         taps_m1, coef_base, dec_m1;
    logic               dual_mode;
    logic [2:0]         out_shift;
    logic               cfg_we;
    logic [8:0]         cfg_addr;
    logic [35:0]        cfg_wdata, cfg_rdata;
    logic               out_valid;
    logic signed [22:0] res_i, res_q;
    logic signed [15:0] out16_i, out16_q;

    rfir_dec uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_ready(in_ready), .taps_m1(taps_m1), .coef_base(coef_base), .dec_m1(dec_m1),
        .dual_mode(dual_mode), .out_shift(out_shift), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .out_valid(out_valid),
        .res_i(res_i), .res_q(res_q), .out16_i(out16_i), .out16_q(out16_q)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic signed [19:0] m_coef [256];
    logic [35:0]        m_hist [256];
    int m_wptr = 0;
    int m_phase = 0;
    longint exp_i, exp_q;

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, input int w);
        longint hi, lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint scale16(input longint r, input int s);
        int sh;
        longint v;
        sh = 7 - s;
        v = r;
        if (sh > 0) v = (v + (longint'(1) <<< (sh - 1))) >>> sh;
        return sat(v, 16);
    endfunction

    function automatic longint fir(input bit q, input int nw, input int base,
                                   input int last, input bit dual);
        longint acc, c, s;
        acc = 0;
        for (int k = 0; k <= last; k++) begin
            c = longint'(m_coef[(base + k + ((dual && q) ? 128 : 0)) % 256]);
            if (q) s = longint'($signed(m_hist[(nw - k + 256) % 256][35:18]));
            else   s = longint'($signed(m_hist[(nw - k + 256) % 256][17:0]));
            acc += c * s;
        end
        return sat(acc >>> 19, 23);
    endfunction

    task automatic cfg_wr(input int a, input logic [35:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 9'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 256) m_hist[a - 256] = d;
        else          m_coef[a] = d[19:0];
    endtask

    task automatic cfg_rd(input int a, output logic [35:0] d);
        @(negedge clk);
        cfg_addr = 9'(a);
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic check_idle_reset();
        chk("R12 in_ready", longint'(in_ready), 1);
        chk("R12 out_valid", longint'(out_valid), 0);
        chk("R12 res_i", longint'(res_i), 0);
        chk("R12 res_q", longint'(res_q), 0);
        chk("R12 out16_i", longint'(out16_i), 0);
        chk("R12 out16_q", longint'(out16_q), 0);
        chk("R12 cfg_rdata", longint'(cfg_rdata), 0);
    endtask

    task automatic push(input int i, input int q, input bit jam);
        bit start;
        int lim, lat, c, nw;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_i = 18'(i); in_q = 18'(q); in_valid = 1'b1;
        @(negedge clk);
        nw = m_wptr;
        m_hist[nw] = {18'(q), 18'(i)};
        m_wptr = (m_wptr + 1) % 256;
        start = (m_phase >= int'(dec_m1));
        m_phase = start ? 0 : m_phase + 1;
        if (jam) begin in_i = 18'h15555; in_q = 18'h2aaaa; end
        else in_valid = 1'b0;
        if (!start) begin
            chk("R6 ready stays high", longint'(in_ready), 1);
            chk("R6 no result pulse", longint'(out_valid), 0);
            return;
        end
        chk("R7 busy after start", longint'(in_ready), 0);
        lim = (dual_mode && taps_m1 > 8'd127) ? 127 : int'(taps_m1);
        lat = dual_mode ? 2 * (lim + 1) + 1 : lim + 2;
        exp_i = fir(1'b0, nw, int'(coef_base), lim, dual_mode);
        exp_q = fir(1'b1, nw, int'(coef_base), lim, dual_mode);
        c = 0;
        while (!out_valid && c < 1000) begin
            @(negedge clk);
            c++;
        end
        in_valid = 1'b0;
        chk("R8 latency", longint'(c), longint'(lat));
        if (dual_mode) begin
            chk("R5 I channel", longint'(res_i), exp_i);
            chk("R5 Q channel", longint'(res_q), exp_q);
        end else begin
            chk("R4 I result", longint'(res_i), exp_i);
            chk("R4 Q result", longint'(res_q), exp_q);
        end
        chk("R10 out16_i", longint'(out16_i), scale16(exp_i, int'(out_shift)));
        chk("R10 out16_q", longint'(out16_q), scale16(exp_q, int'(out_shift)));
        @(negedge clk);
        chk("R8 single pulse", longint'(out_valid), 0);
        chk("R8 held result", longint'(res_i), exp_i);
    endtask

    task automatic shift_sweep();
        for (int s = 0; s < 8; s++) begin
            out_shift = 3'(s);
            #1;
            chk("R10 sweep I", longint'(out16_i), scale16(exp_i, s));
            chk("R10 sweep Q", longint'(out16_q), scale16(exp_q, s));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [35:0] d;
        int bases [3];
        bases[0] = 0; bases[1] = 77; bases[2] = 250;
        rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
        taps_m1 = '0; coef_base = '0; dec_m1 = '0; dual_mode = 1'b0; out_shift = 3'd4;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        check_idle_reset();
        rst_n = 1'b1;

        // R1: load and read back every coefficient
        for (int a = 0; a < 256; a++)
            cfg_wr(a, 36'(((a * 104729 + 333) % 1048576) - 524288) & 36'hfffff);
        for (int a = 0; a < 256; a++) begin
            cfg_rd(a, d);
            chk("R1 coef readback", longint'(d), longint'({16'h0, m_coef[a]}));
        end
        // R2: load and read back every history word
        for (int a = 0; a < 256; a++)
            cfg_wr(256 + a, {18'(a * 9157 + 17), 18'(a * 40503 + 5)});
        for (int a = 0; a < 256; a++) begin
            cfg_rd(256 + a, d);
            chk("R2 hist readback", longint'(d), longint'(m_hist[a]));
        end

        // R4, R11, R3: complex sweep over tap counts and base offsets
        for (int t = 0; t < 16; t++) begin
            for (int b = 0; b < 3; b++) begin
                taps_m1 = 8'(t); coef_base = 8'(bases[b]);
                out_shift = 3'((t + b) % 8);
                push(((t * 7331 + b * 101) % 262144) - 131072,
                     ((t * 5419 + b * 997) % 262144) - 131072, 1'b0);
                if (b == 2) begin
                    cfg_rd(256 + (m_wptr + 255) % 256, d);
                    chk("R3 input stored", longint'(d), longint'(m_hist[(m_wptr + 255) % 256]));
                end
                if (b == 0) shift_sweep();
            end
        end

        // R5: dual mode, short filter and clamped long filter
        dual_mode = 1'b1;
        taps_m1 = 8'd5; coef_base = 8'd10;
        push(1234, -4321, 1'b0);
        taps_m1 = 8'd200; coef_base = 8'd3;
        push(-777, 888, 1'b0);
        dual_mode = 1'b0;

        // R6: decimation by three
        taps_m1 = 8'd3; coef_base = 8'd0; dec_m1 = 8'd2;
        push(100, 200, 1'b0);
        push(300, 400, 1'b0);
        push(500, 600, 1'b0);
        dec_m1 = 8'd0;

        // R7: inputs held during a computation are not stored
        taps_m1 = 8'd6;
        push(4242, -4242, 1'b1);
        cfg_rd(256 + m_wptr, d);
        chk("R7 busy input ignored", longint'(d), longint'(m_hist[m_wptr]));

        // R2, R12: reset keeps history, clears outputs and pointer
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle_reset();
        rst_n = 1'b1;
        m_wptr = 0; m_phase = 0;
        for (int a = 0; a < 8; a++) begin
            cfg_rd(256 + a * 31, d);
            chk("R2 survives reset", longint'(d), longint'(m_hist[a * 31]));
        end
        taps_m1 = 8'd2;
        push(11, -22, 1'b0);
        cfg_rd(256, d);
        chk("R3 pointer restarts", longint'(d), longint'({18'(-22), 18'(11)}));

        // R9: saturation of both lanes
        for (int a = 0; a < 64; a++) cfg_wr(a, 36'h7ffff);
        for (int a = 0; a < 256; a++) cfg_wr(256 + a, {18'h20000, 18'h1ffff});
        taps_m1 = 8'd63; coef_base = 8'd0; out_shift = 3'd7;
        push(131071, -131072, 1'b0);
        chk("R9 positive clip", longint'(res_i), 4194303);
        chk("R9 negative clip", longint'(res_q), -4194304);
        chk("R10 clip I at code 7", longint'(out16_i), 32767);
        chk("R10 clip Q at code 7", longint'(out16_q), -32768);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule